// File: doc/BRIEF.md
# Run-Length Sample Packet Encoder

This block turns a stream of 16-bit logic-analyser samples into run-length records and frames those records as fixed 16-byte packets on a byte-wide valid/ready output. A record carries a sample value and the number of consecutive samples that held it. Every fifth record is followed by a packet sequence byte. The host can then walk the byte stream packet by packet and expand each record back into samples.

A capture begins with a `start` pulse. This clears the sequence number, the record counters and the trigger state. Samples arrive on a valid/ready input. A sample may carry a trigger marker, and the first marker of a capture splits the run there. The count of records completed before that split then gives the trigger position. An `end_cap` pulse flushes the open run and pads the last packet with repeats of the last value until the packet is complete. When every byte has left the block, `cap_done` rises and stays high until the next `start`.

Top module: `rle_sample_packer`

## Requirements
- R1: A record is sent as three bytes in this order: the sample value's low byte, then its high byte, then the repetition count.
- R2: After every five records the block sends one sequence byte, so each packet is exactly 16 bytes and the sequence byte sits at offset 15 of the packet.
- R3: A record closes when an accepted sample differs from the value of the open run, and the record's count equals the number of consecutive equal samples.
- R4: A run of equal samples longer than 255 is split: a record closes with count 255 and the next equal sample opens a new run with count 1.
- R5: The first sample marked as trigger in a capture closes the open run, even when its value is unchanged. `pre_trig_records` then equals the number of records completed before that sample, and `trig_seen` goes high. Later trigger markers in the same capture have no effect on the records or the counters.
- R6: After `end_cap`, the open run is emitted and the packet is filled with records holding the last emitted value and count 1 until it holds five records. `total_records` is then a multiple of 5, `cap_done` goes high, and an end with no samples sends no bytes.
- R7: The sequence byte is 0 in the first packet after `start`, rises by one per packet and wraps from 255 to 0.
- R8: While `out_valid` is high and `out_ready` is low, `out_data` holds its value. While a completed record cannot be handed on, `in_ready` stays low, and no sample is lost.
- R9: After reset, `out_valid` is 0, `in_ready` is 1, `cap_done` is 0 and both record counters are 0.
- R10: No emitted record has a repetition count of 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Pulse that begins a new capture and clears all capture state |
| end_cap | input | 1 | Pulse that ends the capture and triggers flush and padding |
| in_valid | input | 1 | Sample present |
| in_ready | output | 1 | Sample accepted on this cycle when in_valid is also high |
| in_data | input | 16 | Sample value |
| in_trig | input | 1 | Trigger marker attached to the sample |
| out_valid | output | 1 | Output byte present |
| out_ready | input | 1 | Downstream takes the byte |
| out_data | output | 8 | Output byte |
| total_records | output | 32 | Records emitted in this capture, padding included |
| pre_trig_records | output | 32 | Records completed before the first trigger sample |
| trig_seen | output | 1 | A trigger marker has been taken in this capture |
| cap_done | output | 1 | Flush finished and all bytes sent |

## Verification
The bench builds the block with its default parameters: 16-bit samples, an 8-bit count and five records per packet. At this size the 255-count split is reached with a 300-sample run, and the sequence wrap is reached with 1285 single-sample records (257 packets). It sweeps run lengths from 1 to 20 with a trigger in the middle of a run, and it varies output backpressure. Each capture's byte stream is compared with a stream computed in the bench from the run rules.

// File: rtl/rle_pkg.sv
package rle_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [0:0] {
    PH_REC = 1'b0,
    PH_SEQ = 1'b1
  } ser_phase_e;
endpackage

// File: rtl/rle_run_builder.sv
module rle_run_builder #(
  parameter int DATA_W = 16,
  parameter int CNT_W  = 8,
  parameter int RECS   = 5,
  parameter int CNTR_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              end_cap,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_trig,
  output logic              rec_valid,
  input  logic              rec_ready,
  output logic [DATA_W-1:0] rec_val,
  output logic [CNT_W-1:0]  rec_cnt,
  input  logic              ser_idle,
  output logic [CNTR_W-1:0] total_records,
  output logic [CNTR_W-1:0] pre_trig_records,
  output logic              trig_seen,
  output logic              cap_done
);
  localparam int RUN_MAX = (1 << CNT_W) - 1;
  localparam int MOD_W   = (RECS > 1) ? $clog2(RECS) : 1;

  logic              open_q;
  logic [DATA_W-1:0] run_val_q;
  logic [CNT_W-1:0]  run_cnt_q;
  logic              flush_q;
  logic              done_q;
  logic [MOD_W-1:0]  mod_q;
  logic              rec_valid_q;
  logic [DATA_W-1:0] rec_val_q;
  logic [CNT_W-1:0]  rec_cnt_q;
  logic [CNTR_W-1:0] total_q;
  logic [CNTR_W-1:0] pre_q;
  logic              trig_q;

  logic              in_fire;
  logic              trig_new;
  logic              close_run;
  logic              flush_slot;
  logic              issue;
  logic [DATA_W-1:0] iss_val;
  logic [CNT_W-1:0]  iss_cnt;

  assign in_ready   = !rec_valid_q && !flush_q && !done_q;
  assign in_fire    = in_valid && in_ready;
  assign trig_new   = in_trig && !trig_q;
  assign close_run  = open_q && ((in_data != run_val_q) ||
                                 (run_cnt_q == CNT_W'(RUN_MAX)) || trig_new);
  assign flush_slot = flush_q && !rec_valid_q;

  always_comb begin
    issue   = 1'b0;
    iss_val = run_val_q;
    iss_cnt = run_cnt_q;
    if (in_fire && close_run) begin
      issue = 1'b1;
    end else if (flush_slot) begin
      if (open_q) begin
        issue = 1'b1;
      end else if (mod_q != '0) begin
        issue   = 1'b1;
        iss_val = rec_val_q;
        iss_cnt = CNT_W'(1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst || start) begin
      open_q      <= 1'b0;
      run_val_q   <= '0;
      run_cnt_q   <= '0;
      flush_q     <= 1'b0;
      done_q      <= 1'b0;
      mod_q       <= '0;
      rec_valid_q <= 1'b0;
      rec_val_q   <= '0;
      rec_cnt_q   <= '0;
      total_q     <= '0;
      pre_q       <= '0;
      trig_q      <= 1'b0;
    end else begin
      if (rec_valid_q && rec_ready) begin
        rec_valid_q <= 1'b0;
      end
      if (issue) begin
        rec_valid_q <= 1'b1;
        rec_val_q   <= iss_val;
        rec_cnt_q   <= iss_cnt;
        total_q     <= total_q + 1'b1;
        mod_q       <= (mod_q == MOD_W'(RECS - 1)) ? '0 : mod_q + 1'b1;
      end
      if (in_fire) begin
        if (!open_q || close_run) begin
          open_q    <= 1'b1;
          run_val_q <= in_data;
          run_cnt_q <= CNT_W'(1);
        end else begin
          run_cnt_q <= run_cnt_q + 1'b1;
        end
        if (trig_new) begin
          trig_q <= 1'b1;
          pre_q  <= total_q + CNTR_W'(close_run);
        end
      end else if (flush_slot && open_q) begin
        open_q <= 1'b0;
      end
      if (end_cap && !done_q) begin
        flush_q <= 1'b1;
      end
      if (flush_slot && !open_q && (mod_q == '0) && ser_idle) begin
        done_q  <= 1'b1;
        flush_q <= 1'b0;
      end
    end
  end

  assign rec_valid        = rec_valid_q;
  assign rec_val          = rec_val_q;
  assign rec_cnt          = rec_cnt_q;
  assign total_records    = total_q;
  assign pre_trig_records = pre_q;
  assign trig_seen        = trig_q;
  assign cap_done         = done_q;

  // R10: a handed-on record never carries a zero count
  assert_rec_nonzero_R10: assert property (@(posedge clk) disable iff (rst)
    rec_valid_q |-> (rec_cnt_q != '0));

  // R8: a record waiting for the serializer is held unchanged
  assert_rec_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (rec_valid_q && !rec_ready && !start) |=>
      (rec_valid_q && $stable(rec_cnt_q) && $stable(rec_val_q)));

  // R8: no sample is taken while a record is still pending
  assert_no_take_pending_R8: assert property (@(posedge clk) disable iff (rst)
    (rec_valid_q && !rec_ready && !start) |=> !in_ready);
endmodule

// File: rtl/rle_packet_serializer.sv
module rle_packet_serializer
  import rle_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int CNT_W  = 8,
  parameter int RECS   = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              rec_valid,
  output logic              rec_ready,
  input  logic [DATA_W-1:0] rec_val,
  input  logic [CNT_W-1:0]  rec_cnt,
  output logic              ser_idle,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [BYTE_W-1:0] out_data
);
  localparam int VAL_BYTES = DATA_W / BYTE_W;
  localparam int CNT_BYTES = CNT_W / BYTE_W;
  localparam int REC_BYTES = VAL_BYTES + CNT_BYTES;
  localparam int REC_BITS  = REC_BYTES * BYTE_W;
  localparam int IDX_W     = (REC_BYTES > 1) ? $clog2(REC_BYTES) : 1;
  localparam int SLOT_W    = (RECS > 1) ? $clog2(RECS) : 1;

  logic [REC_BITS-1:0] rec_word;
  logic [REC_BITS-1:0] shreg_q;
  logic                busy_q;
  ser_phase_e          phase_q;
  logic [IDX_W-1:0]    idx_q;
  logic [SLOT_W-1:0]   slot_q;
  logic [BYTE_W-1:0]   seq_q;

  for (genvar g = 0; g < REC_BYTES; g++) begin : g_lane
    if (g < VAL_BYTES) begin : g_val
      assign rec_word[g*BYTE_W +: BYTE_W] = rec_val[g*BYTE_W +: BYTE_W];
    end else begin : g_cnt
      assign rec_word[g*BYTE_W +: BYTE_W] = rec_cnt[(g-VAL_BYTES)*BYTE_W +: BYTE_W];
    end
  end

  always_ff @(posedge clk) begin
    if (rst || start) begin
      shreg_q <= '0;
      busy_q  <= 1'b0;
      phase_q <= PH_REC;
      idx_q   <= '0;
      slot_q  <= '0;
      seq_q   <= '0;
    end else if (!busy_q) begin
      if (rec_valid) begin
        busy_q  <= 1'b1;
        shreg_q <= rec_word;
        idx_q   <= '0;
        phase_q <= PH_REC;
      end
    end else if (out_ready) begin
      if (phase_q == PH_SEQ) begin
        seq_q   <= seq_q + 1'b1;
        slot_q  <= '0;
        busy_q  <= 1'b0;
        phase_q <= PH_REC;
      end else if (idx_q != IDX_W'(REC_BYTES - 1)) begin
        idx_q   <= idx_q + 1'b1;
        shreg_q <= shreg_q >> BYTE_W;
      end else if (slot_q == SLOT_W'(RECS - 1)) begin
        phase_q <= PH_SEQ;
        shreg_q <= REC_BITS'(seq_q);
      end else begin
        slot_q <= slot_q + 1'b1;
        busy_q <= 1'b0;
      end
    end
  end

  assign rec_ready = !busy_q;
  assign ser_idle  = !busy_q;
  assign out_valid = busy_q;
  assign out_data  = shreg_q[BYTE_W-1:0];

  // R8: a stalled byte stays put
  assert_out_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready && !start) |=> (out_valid && $stable(out_data)));

  // R2: the record slot index stays within one packet
  assert_slot_range_R2: assert property (@(posedge clk) disable iff (rst)
    slot_q < SLOT_W'(RECS));

  // R7: each sent sequence byte advances the packet number by one
  assert_seq_step_R7: assert property (@(posedge clk) disable iff (rst)
    (busy_q && out_ready && (phase_q == PH_SEQ) && !start) |=>
      (seq_q == $past(seq_q) + 1'b1));
endmodule

// File: rtl/rle_sample_packer.sv
module rle_sample_packer #(
  parameter int DATA_W = 16,
  parameter int CNT_W  = 8,
  parameter int RECS   = 5,
  parameter int CNTR_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              end_cap,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_trig,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [7:0]        out_data,
  output logic [CNTR_W-1:0] total_records,
  output logic [CNTR_W-1:0] pre_trig_records,
  output logic              trig_seen,
  output logic              cap_done
);
  logic              rec_valid;
  logic              rec_ready;
  logic [DATA_W-1:0] rec_val;
  logic [CNT_W-1:0]  rec_cnt;
  logic              ser_idle;

  rle_run_builder #(
    .DATA_W(DATA_W), .CNT_W(CNT_W), .RECS(RECS), .CNTR_W(CNTR_W)
  ) u_build (
    .clk(clk), .rst(rst), .start(start), .end_cap(end_cap),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data), .in_trig(in_trig),
    .rec_valid(rec_valid), .rec_ready(rec_ready), .rec_val(rec_val), .rec_cnt(rec_cnt),
    .ser_idle(ser_idle), .total_records(total_records),
    .pre_trig_records(pre_trig_records), .trig_seen(trig_seen), .cap_done(cap_done)
  );

  rle_packet_serializer #(
    .DATA_W(DATA_W), .CNT_W(CNT_W), .RECS(RECS)
  ) u_ser (
    .clk(clk), .rst(rst), .start(start),
    .rec_valid(rec_valid), .rec_ready(rec_ready), .rec_val(rec_val), .rec_cnt(rec_cnt),
    .ser_idle(ser_idle), .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
  );

  // R6: a finished capture holds whole packets only
  assert_done_aligned_R6: assert property (@(posedge clk) disable iff (rst)
    cap_done |-> ((total_records % CNTR_W'(RECS)) == '0));

  // R6: nothing is left to send once done is reported
  assert_done_drained_R6: assert property (@(posedge clk) disable iff (rst)
    cap_done |-> (!out_valid && !in_ready));

  // R5: the trigger position never lies past the records emitted
  assert_pre_bound_R5: assert property (@(posedge clk) disable iff (rst)
    trig_seen |-> (pre_trig_records <= total_records));
endmodule

// File: tb/sim_rle_sample_packer.sv
module sim_rle_sample_packer;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic        end_cap = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [15:0] in_data = '0;
  logic        in_trig = 1'b0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [7:0]  out_data;
  logic [31:0] total_records;
  logic [31:0] pre_trig_records;
  logic        trig_seen;
  logic        cap_done;

  rle_sample_packer u0 (
    .clk(clk), .rst(rst), .start(start), .end_cap(end_cap),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data), .in_trig(in_trig),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .total_records(total_records), .pre_trig_records(pre_trig_records),
    .trig_seen(trig_seen), .cap_done(cap_done)
  );

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int rmode = 0;
  logic [7:0] lfsr = 8'h5b;
  logic [7:0] got [0:8191];
  logic [7:0] expb [0:8191];
  int ngot = 0;
  int nexp = 0;

  bit          mopen, mtrig;
  logic [15:0] mval, mlast;
  int          mcnt, mslot, missued, mpre;
  logic [7:0]  mseq;

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  always @(negedge clk) begin
    cyc++;
    lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    out_ready = (rmode == 0) ? 1'b1 : (rmode == 1) ? (lfsr[0] | lfsr[1]) : 1'b0;
    if (!rst && out_valid && out_ready) begin
      if (ngot < 8192) got[ngot] = out_data;
      ngot++;
    end
    if (cyc > 190000) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected fewer than 190000", cyc);
      summary();
      $finish;
    end
  end

  task automatic chk(bit ok, string tag, string what, int act, int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, expv);
    end
  endtask

  task automatic m_emit(logic [15:0] v, int c);
    expb[nexp] = v[7:0];  nexp++;
    expb[nexp] = v[15:8]; nexp++;
    expb[nexp] = c[7:0];  nexp++;
    missued++;
    mlast = v;
    mslot++;
    if (mslot == 5) begin
      expb[nexp] = mseq; nexp++;
      mseq++;
      mslot = 0;
    end
  endtask

  task automatic mput(logic [15:0] v, bit t);
    bit tn;
    tn = t && !mtrig;
    if (mopen && (v != mval || mcnt == 255 || tn)) begin
      m_emit(mval, mcnt);
      mval = v; mcnt = 1;
    end else if (mopen) begin
      mcnt++;
    end else begin
      mopen = 1; mval = v; mcnt = 1;
    end
    if (tn) begin
      mtrig = 1;
      mpre = missued;
    end
  endtask

  task automatic drive(logic [15:0] v, bit t);
    in_valid = 1'b1; in_data = v; in_trig = t;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 1'b0; in_trig = 1'b0;
  endtask

  task automatic put(logic [15:0] v, bit t);
    mput(v, t);
    drive(v, t);
  endtask

  task automatic begin_cap();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    mopen = 0; mtrig = 0; mval = '0; mlast = '0; mcnt = 0;
    mslot = 0; missued = 0; mpre = 0; mseq = '0;
    ngot = 0; nexp = 0;
  endtask

  task automatic finish_cap();
    if (mopen) m_emit(mval, mcnt);
    mopen = 0;
    while (mslot != 0) m_emit(mlast, 1);
    end_cap = 1'b1;
    @(negedge clk); end_cap = 1'b0;
    while (!cap_done) @(negedge clk);
    repeat (3) @(negedge clk);
    chk(cap_done == 1'b1, "R6", "cap_done", int'(cap_done), 1);
  endtask

  task automatic cmp(string tag);
    chk(ngot == nexp, tag, "byte count", ngot, nexp);
    for (int i = 0; i < nexp && i < ngot; i++)
      chk(got[i] == expb[i], tag, $sformatf("byte %0d", i), int'(got[i]), int'(expb[i]));
    chk(total_records == 32'(missued), "R6", "total_records", int'(total_records), missued);
    chk((total_records % 5) == 0, "R6", "total multiple of 5", int'(total_records % 5), 0);
    chk(trig_seen == mtrig, "R5", "trig_seen", int'(trig_seen), int'(mtrig));
    if (mtrig)
      chk(pre_trig_records == 32'(mpre), "R5", "pre_trig_records", int'(pre_trig_records), mpre);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R9 reset state
    chk(out_valid == 1'b0, "R9", "out_valid", int'(out_valid), 0);
    chk(in_ready == 1'b1, "R9", "in_ready", int'(in_ready), 1);
    chk(cap_done == 1'b0, "R9", "cap_done", int'(cap_done), 0);
    chk(total_records == 0, "R9", "total_records", int'(total_records), 0);
    chk(pre_trig_records == 0, "R9", "pre_trig_records", int'(pre_trig_records), 0);

    // S1: byte order and padding (R1, R6)
    begin_cap();
    rmode = 1;
    for (int i = 0; i < 3; i++) put(16'h1234, 1'b0);
    put(16'hABCD, 1'b0);
    for (int i = 0; i < 2; i++) put(16'h00F0, 1'b0);
    finish_cap();
    cmp("R1");
    chk(got[0] == 8'h34, "R1", "value low byte", int'(got[0]), 8'h34);
    chk(got[1] == 8'h12, "R1", "value high byte", int'(got[1]), 8'h12);
    chk(got[2] == 8'd3, "R1", "count byte", int'(got[2]), 3);
    chk(got[12] == 8'hF0 && got[14] == 8'd1, "R6", "pad record", int'(got[14]), 1);
    chk(got[15] == 8'd0, "R7", "first sequence byte", int'(got[15]), 0);

    // S2: saturation split (R4)
    begin_cap();
    for (int i = 0; i < 300; i++) put(16'h00FF, 1'b0);
    put(16'h0F0F, 1'b0);
    finish_cap();
    cmp("R4");
    chk(got[2] == 8'd255, "R4", "saturated count", int'(got[2]), 255);
    chk(got[5] == 8'd45, "R4", "remainder count", int'(got[5]), 45);

    // S3: trigger inside a run, second marker ignored (R5)
    begin_cap();
    put(16'hAAAA, 1'b0);
    put(16'hAAAA, 1'b0);
    put(16'hAAAA, 1'b1);
    put(16'hAAAA, 1'b0);
    put(16'hAAAA, 1'b0);
    put(16'h5555, 1'b0);
    put(16'h5555, 1'b1);
    finish_cap();
    cmp("R5");
    chk(pre_trig_records == 1, "R5", "trigger position", int'(pre_trig_records), 1);
    chk(got[2] == 8'd2 && got[5] == 8'd3, "R5", "split counts", int'(got[5]), 3);
    chk(got[8] == 8'd2, "R5", "later marker ignored", int'(got[8]), 2);

    // S3b: trigger on the first sample
    begin_cap();
    put(16'h0101, 1'b1);
    put(16'h0101, 1'b0);
    finish_cap();
    cmp("R5");
    chk(pre_trig_records == 0, "R5", "trigger at first sample", int'(pre_trig_records), 0);

    // S4: empty capture (R6)
    begin_cap();
    finish_cap();
    chk(ngot == 0, "R6", "empty capture bytes", ngot, 0);
    chk(total_records == 0, "R6", "empty capture records", int'(total_records), 0);

    // S5: backpressure stall (R8)
    begin_cap();
    rmode = 2;
    put(16'h1111, 1'b0);
    put(16'h2222, 1'b0);
    put(16'h3333, 1'b0);
    mput(16'h4444, 1'b0);
    in_valid = 1'b1; in_data = 16'h4444; in_trig = 1'b0;
    repeat (8) @(negedge clk);
    chk(in_ready == 1'b0, "R8", "in_ready under stall", int'(in_ready), 0);
    chk(out_valid == 1'b1, "R8", "out_valid under stall", int'(out_valid), 1);
    chk(out_data == 8'h11, "R8", "held byte", int'(out_data), 8'h11);
    rmode = 1;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    finish_cap();
    cmp("R8");

    // S6: run length sweep with a mid-run trigger (R3, R10)
    begin_cap();
    for (int len = 1; len <= 20; len++)
      for (int k = 0; k < len; k++)
        put(16'(len * 16'h0111), (len == 9 && k == 4));
    finish_cap();
    cmp("R3");
    for (int p = 0; p < ngot / 16; p++)
      for (int r = 0; r < 5; r++)
        chk(got[p*16 + r*3 + 2] != 8'd0, "R10", "count nonzero", int'(got[p*16 + r*3 + 2]), 1);

    // S7: many packets, sequence wrap (R2, R7)
    begin_cap();
    for (int i = 0; i < 1285; i++) put(16'(i * 3 + 1), 1'b0);
    finish_cap();
    cmp("R2");
    chk(ngot == 257 * 16, "R2", "packet framing", ngot, 257 * 16);
    chk(got[255*16 + 15] == 8'd255, "R7", "sequence 255", int'(got[255*16 + 15]), 255);
    chk(got[256*16 + 15] == 8'd0, "R7", "sequence wrap", int'(got[256*16 + 15]), 0);

    // S8: restart clears the sequence (R7)
    begin_cap();
    rmode = 0;
    for (int i = 0; i < 5; i++) put(16'(16'h7000 + i), 1'b0);
    finish_cap();
    cmp("R7");
    chk(got[15] == 8'd0, "R7", "sequence after restart", int'(got[15]), 0);

    summary();
    $finish;
  end
endmodule